// File: doc/BRIEF.md
# Square-Tone Sound Channel with Mixer

This block is one voice of a three-voice programmable sound generator. A 12-bit period value sets a square wave derived from the master clock. The square wave can be combined with a noise bit that all voices share. The combined gate then selects between silence and a 16-bit sample level. That level comes from a fixed non-linear 16-step loudness table, indexed either by a fixed 4-bit volume or by an envelope level supplied from outside.

Software configures the channel through a byte-wide register port that writes on a single strobe. There are four registers:

- Address 0 holds the low byte of the period.
- Address 1 holds the period high nibble in bits 3:0.
- Address 2 holds the mixer control.
- Address 3 holds the amplitude control.

The noise generator and the envelope generator sit outside this block. Their outputs arrive on the `noiseBit` and `envLevel` inputs.

Top module: `tone_chan`

## Requirements
- R1: After an asserted active-low reset, `toneOut` and `sampleOut` are 0, and every register is 0. A zero register value means period 0, both sources enabled and fixed volume 0.
- R2: The period P is {address 1 bits 3:0, address 0 bits 7:0}. `toneOut` toggles once every 8*P clocks, so one full square cycle lasts 16*P clocks, for every P from 1 to 4095.
- R3: A period of 0 gives exactly the same toggle spacing as a period of 1, which is 8 clocks.
- R4: Mixer register bit 0 set to 1 disables the tone, and bit 1 set to 1 disables the noise. A disabled source counts as logic 1. The channel gate is the AND of the two sources.
- R5: When the gate is 0, `sampleOut` is 0.
- R6: Amplitude register bits 3:0 hold the fixed volume. When amplitude register bit 4 is 1, `envLevel` is used in place of the fixed volume.
- R7: When the gate is 1, amplitude codes 0 through 15 produce samples 0, 231, 695, 1158, 2084, 2779, 4168, 6716, 8105, 13200, 18294, 24315, 32189, 40757, 52799 and 65535 respectively.
- R8: `sampleOut` is registered. It reflects the gate and the amplitude present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | 8 | Register write data |
| noiseBit | input | 1 | Shared noise source level |
| envLevel | input | 4 | Envelope amplitude level |
| toneOut | output | 1 | Raw square-wave tone level |
| sampleOut | output | 16 | Output sample level |

## Verification
On every cycle, the assertions check the following:
- The prescaler strobe never fires on two cycles in a row.
- The effective period is never zero.
- The tone level changes only on a strobe and always leaves the period counter at zero.
- A closed gate always yields a zero sample.

Only the bench scenarios can show the rest. These are the actual toggle spacing for several periods (including 0 and 4095), the table value delivered for particular volume and envelope codes, the AND behaviour of the mixer, and the one-clock latency of the sample.

// File: rtl/tone_chan_pkg.sv
package tone_chan_pkg;
  localparam int PERIOD_W = 12;
  localparam int VOL_W    = 4;
  localparam int SAMPLE_W = 16;

  typedef struct packed {
    logic                tick;
    logic                toneOff;
    logic                noiseOff;
    logic                useEnv;
    logic [VOL_W-1:0]    fixedVol;
    logic [PERIOD_W-1:0] periodEff;
  } chanCtrlT;

  function automatic logic [SAMPLE_W-1:0] levelLut(input logic [VOL_W-1:0] code);
    case (code)
      4'd0:    levelLut = 16'd0;
      4'd1:    levelLut = 16'd231;
      4'd2:    levelLut = 16'd695;
      4'd3:    levelLut = 16'd1158;
      4'd4:    levelLut = 16'd2084;
      4'd5:    levelLut = 16'd2779;
      4'd6:    levelLut = 16'd4168;
      4'd7:    levelLut = 16'd6716;
      4'd8:    levelLut = 16'd8105;
      4'd9:    levelLut = 16'd13200;
      4'd10:   levelLut = 16'd18294;
      4'd11:   levelLut = 16'd24315;
      4'd12:   levelLut = 16'd32189;
      4'd13:   levelLut = 16'd40757;
      4'd14:   levelLut = 16'd52799;
      default: levelLut = 16'd65535;
    endcase
  endfunction
endpackage

// File: rtl/tone_chan_ctrl.sv
module tone_chan_ctrl
  import tone_chan_pkg::*;
#(
  parameter int PRE_LOG = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output chanCtrlT ctrl
);
  localparam int HI_W = PERIOD_W - 8;

  logic [7:0]         periodLo;
  logic [HI_W-1:0]    periodHi;
  logic [1:0]         mixReg;
  logic [VOL_W:0]     ampReg;
  logic [PRE_LOG-1:0] preCnt;
  logic [PERIOD_W-1:0] periodRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodLo <= '0;
      periodHi <= '0;
      mixReg   <= '0;
      ampReg   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        2'd0: periodLo <= wrData;
        2'd1: periodHi <= wrData[HI_W-1:0];
        2'd2: mixReg   <= wrData[1:0];
        default: ampReg <= wrData[VOL_W:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    periodRaw      = {periodHi, periodLo};
    ctrl.tick      = &preCnt;
    ctrl.toneOff   = mixReg[0];
    ctrl.noiseOff  = mixReg[1];
    ctrl.useEnv    = ampReg[VOL_W];
    ctrl.fixedVol  = ampReg[VOL_W-1:0];
    ctrl.periodEff = (periodRaw == '0) ? PERIOD_W'(1) : periodRaw;
  end

  // R2: the prescaler strobe is a single-cycle pulse
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.tick |=> !ctrl.tick);

  // R3: the zero period is folded onto one
  p_period_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.periodEff != '0);
endmodule

// File: rtl/tone_chan_dp.sv
module tone_chan_dp
  import tone_chan_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  chanCtrlT            ctrl,
  input  logic                noiseBit,
  input  logic [VOL_W-1:0]    envLevel,
  output logic                toneOut,
  output logic [SAMPLE_W-1:0] sampleOut
);
  logic [PERIOD_W-1:0] cnt;
  logic                toneQ;
  logic                gate;
  logic [VOL_W-1:0]    ampSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      toneQ <= 1'b0;
    end else if (ctrl.tick) begin
      if (cnt >= ctrl.periodEff - 1'b1) begin
        cnt   <= '0;
        toneQ <= ~toneQ;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    gate   = (toneQ | ctrl.toneOff) & (noiseBit | ctrl.noiseOff);
    ampSel = ctrl.useEnv ? envLevel : ctrl.fixedVol;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     sampleOut <= '0;
    else if (gate) sampleOut <= levelLut(ampSel);
    else           sampleOut <= '0;
  end

  assign toneOut = toneQ;

  // R2: tone level only moves on a prescaler strobe
  p_tone_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.tick |=> $stable(toneQ));

  // R2: every toggle restarts the period count
  p_toggle_restarts_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(toneQ) |-> cnt == '0);

  // R5: a closed gate yields silence one clock later
  p_gate_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    !gate |=> sampleOut == '0);
endmodule

// File: rtl/tone_chan.sv
module tone_chan
  import tone_chan_pkg::*;
#(
  parameter int PRE_LOG = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic        noiseBit,
  input  logic [3:0]  envLevel,
  output logic        toneOut,
  output logic [15:0] sampleOut
);
  chanCtrlT ctrlBus;

  tone_chan_ctrl #(.PRE_LOG(PRE_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ctrl(ctrlBus)
  );

  tone_chan_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .noiseBit(noiseBit),
    .envLevel(envLevel), .toneOut(toneOut), .sampleOut(sampleOut)
  );
endmodule

// File: tb/tone_chan_test.sv
`timescale 1ns/1ps
module tone_chan_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        noiseBit = 1'b0;
  logic [3:0]  envLevel = '0;
  logic        toneOut;
  logic [15:0] sampleOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    int    expVal;
  } expItemT;
  expItemT sb[$];

  always #2.5 clk = ~clk;

  tone_chan uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .noiseBit(noiseBit), .envLevel(envLevel), .toneOut(toneOut), .sampleOut(sampleOut)
  );

  function automatic int lutRef(input int code);
    int tbl[16] = '{0, 231, 695, 1158, 2084, 2779, 4168, 6716,
                    8105, 13200, 18294, 24315, 32189, 40757, 52799, 65535};
    return tbl[code];
  endfunction

  task automatic expectVal(input string tag, input int v);
    expItemT it;
    it.tag = tag;
    it.expVal = v;
    sb.push_back(it);
  endtask

  task automatic monitorPop(input int actual);
    expItemT it;
    it = sb.pop_front();
    nChecks++;
    if (actual != it.expVal) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", it.tag, actual, it.expVal);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measureSpacing(input int p, input string tag);
    logic prev;
    int n;
    prev = toneOut;
    while (toneOut == prev) @(negedge clk);
    prev = toneOut;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (toneOut == prev);
    expectVal(tag, 8 * ((p == 0) ? 1 : p));
    monitorPop(n);
  endtask

  task automatic setPeriod(input int p);
    regWrite(2'd0, 8'(p & 8'hFF));
    regWrite(2'd1, 8'(p >> 8));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic prevTone;
    repeat (3) @(negedge clk);
    // R1 reset state
    expectVal("R1 toneOut", 0);      monitorPop(toneOut);
    expectVal("R1 sampleOut", 0);    monitorPop(sampleOut);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    expectVal("R1 sampleOut after release", 0); monitorPop(sampleOut);

    // R3 default period 0 acts as 1
    measureSpacing(0, "R3 zero period at reset");
    measureSpacing(1, "R2 period 1");
    setPeriod(3);
    measureSpacing(3, "R2 period 3");
    setPeriod(0);
    measureSpacing(0, "R3 period written 0");
    setPeriod(261);
    measureSpacing(261, "R2 period 261");

    // R4/R7 both sources disabled: gate open
    setPeriod(1);
    regWrite(2'd2, 8'h03);
    regWrite(2'd3, 8'h09);
    @(negedge clk);
    expectVal("R7 vol 9", lutRef(9));   monitorPop(sampleOut);
    regWrite(2'd3, 8'h0F);
    @(negedge clk);
    expectVal("R7 vol 15", lutRef(15)); monitorPop(sampleOut);
    regWrite(2'd3, 8'h00);
    @(negedge clk);
    expectVal("R7 vol 0", 0);           monitorPop(sampleOut);
    regWrite(2'd3, 8'h04);
    @(negedge clk);
    expectVal("R7 vol 4", lutRef(4));   monitorPop(sampleOut);

    // R6 envelope mode
    envLevel = 4'd5;
    regWrite(2'd3, 8'h10);
    @(negedge clk);
    expectVal("R6 env 5", lutRef(5));   monitorPop(sampleOut);
    envLevel = 4'd12;
    @(negedge clk);
    expectVal("R6 env 12", lutRef(12)); monitorPop(sampleOut);
    envLevel = 4'd7;
    regWrite(2'd3, 8'h13);
    @(negedge clk);
    expectVal("R6 env 7 ignores fixed 3", lutRef(7)); monitorPop(sampleOut);
    regWrite(2'd3, 8'h03);
    @(negedge clk);
    expectVal("R6 fixed 3 ignores env", lutRef(3)); monitorPop(sampleOut);

    // R5/R8 noise only
    regWrite(2'd3, 8'h0F);
    regWrite(2'd2, 8'h01);
    noiseBit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expectVal("R5 noise low silences", 0); monitorPop(sampleOut);
    noiseBit = 1'b1;
    expectVal("R8 no change before edge", 0); monitorPop(sampleOut);
    @(negedge clk);
    expectVal("R8 one-clock latency", lutRef(15)); monitorPop(sampleOut);

    // R4 tone only, sample follows the tone
    regWrite(2'd2, 8'h02);
    noiseBit = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      prevTone = toneOut;
      @(negedge clk);
      expectVal("R4 tone only", prevTone ? lutRef(15) : 0);
      monitorPop(sampleOut);
    end

    // R4 both enabled, noise low blocks tone
    regWrite(2'd2, 8'h00);
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      expectVal("R4 AND with noise low", 0);
      monitorPop(sampleOut);
    end
    // R4 both enabled, noise high passes tone
    noiseBit = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      prevTone = toneOut;
      @(negedge clk);
      expectVal("R4 AND with noise high", prevTone ? lutRef(15) : 0);
      monitorPop(sampleOut);
    end

    // R2 maximum period
    setPeriod(4095);
    measureSpacing(4095, "R2 period 4095");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule